// File: doc/BRIEF.md
# Block-Aligned 384-Slot Serial Audio Receiver

This block takes serial audio from an external digital audio receiver chip whose natural unit is a block of 384 subframes. The bit clock of the link is the block's clock. The sync input carries a start-of-block pulse from that chip, not a left/right word clock. Every slot in the block is treated as active. On each bit clock the block samples one bit from each of its data pins. After 32 bits it has a full word for the current slot on every pin.

Each finished slot comes out for one cycle, with a strobe and the slot number. A separate flag marks slot 383, so an event at the end of each block tracks the external audio stream. If a start-of-block pulse arrives before the block is complete, the receiver realigns to slot 0 and keeps a sticky error flag until reset.

Top module: `blk_tdm_rx`

## Requirements
- R1: After reset all outputs are 0 and the receiver hunts for alignment. Until the first sync pulse is sampled high, no word is produced, whatever arrives on the data pins. Reset also clears the error flag.
- R2: When the sync input is sampled high on a clock edge, the bit sampled on the following edge is bit 0 of slot 0. The data bit sampled together with the pulse is not part of slot 0.
- R3: A slot lasts 32 bit clocks, and data arrives MSB first. The first bit of a slot lands in bit 31 of that pin's word, and the last bit lands in bit 0.
- R4: `word_valid` is high for exactly one cycle, the cycle after the last bit of a slot was sampled. In that cycle `slot_idx` and `word_data` hold that slot's number and words.
- R5: A block holds 384 slots, numbered 0 to 383, and every slot produces a word. No slot can be masked.
- R6: `last_slot` is high only together with the `word_valid` of slot 383.
- R7: If no sync pulse arrives, the slot count runs freely and wraps from slot 383 to slot 0.
- R8: A sync pulse sampled at any other point than the last bit of slot 383 is handled as follows. The unfinished slot is dropped without a strobe. The count restarts at slot 0, as in R2. `sync_err` goes high and stays high until reset. A pulse on the last bit of slot 383, or one received while hunting, leaves `sync_err` unchanged.
- R9: All data pins share one slot timing, and each pin assembles its own word. Pin p fills `word_data[p*32 +: 32]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Start-of-block pulse from the external receiver |
| sdata | input | LANES | Serial data, one bit per pin |
| word_valid | output | 1 | One-cycle strobe for a finished slot |
| slot_idx | output | 9 | Number of the finished slot |
| word_data | output | LANES*32 | Finished words, pin p in bits p*32 +: 32 |
| last_slot | output | 1 | High with the strobe of slot 383 |
| sync_err | output | 1 | Sticky flag for an early block-start pulse |

## Verification
The bench drives the data bit that arrives together with each sync pulse as all ones. A receiver that takes that bit into slot 0 shows up as a one-bit shift across every word on both pins. It sends a pulse halfway through a slot. A design that emits the broken slot, or that fails to restart at 0, then produces an unexpected word or wrong slot numbers; the same test catches an error flag that never sets or does not stay set. It runs a whole block with no pulse, which catches a counter that stalls or overruns at 383. It also sends noise while the receiver is hunting, which catches a block that produces words before it is aligned.

// File: rtl/blk_tdm_rx_pkg.sv
package blk_tdm_rx_pkg;

    localparam int DEF_SLOTS     = 384;
    localparam int DEF_SLOT_BITS = 32;
    localparam int DEF_LANES     = 2;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic word_done;   // last bit of a slot is being sampled
        logic block_end;   // last bit of the final slot is being sampled
        logic early_sync;  // block start seen off the expected position
    } rx_evt_t;

    function automatic int idx_bits(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/blk_tdm_rx_timing.sv
module blk_tdm_rx_timing
    import blk_tdm_rx_pkg::*;
#(
    parameter int SLOTS     = DEF_SLOTS,
    parameter int SLOT_BITS = DEF_SLOT_BITS,
    parameter int SW        = idx_bits(SLOTS),
    parameter int BW        = idx_bits(SLOT_BITS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fsync,
    output rx_state_e       state,
    output logic [BW-1:0]   bit_idx,
    output logic [SW-1:0]   slot_idx,
    output rx_evt_t         evt,
    output logic            sync_err
);

    localparam logic [BW-1:0] LAST_BIT  = BW'(SLOT_BITS - 1);
    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

    // Events for the bit being sampled on this edge
    always_comb begin
        evt.word_done  = (state == ST_LOCK) && (bit_idx == LAST_BIT);
        evt.block_end  = evt.word_done && (slot_idx == LAST_SLOT);
        evt.early_sync = fsync && (state == ST_LOCK) && !evt.block_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_HUNT;
            bit_idx  <= '0;
            slot_idx <= '0;
            sync_err <= 1'b0;
        end else begin
            if (fsync) begin
                state    <= ST_LOCK;
                bit_idx  <= '0;
                slot_idx <= '0;
            end else if (state == ST_LOCK) begin
                if (bit_idx == LAST_BIT) begin
                    bit_idx  <= '0;
                    slot_idx <= (slot_idx == LAST_SLOT) ? '0 : slot_idx + 1'b1;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end
            if (evt.early_sync) begin
                sync_err <= 1'b1;
            end
        end
    end

    AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (rst)
        fsync |=> (state == ST_LOCK) && (bit_idx == '0) && (slot_idx == '0)); // R2

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        sync_err |=> sync_err); // R8

    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_LOCK) && !fsync && (bit_idx == LAST_BIT) && (slot_idx == LAST_SLOT))
        |=> (slot_idx == '0)); // R7

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        slot_idx <= LAST_SLOT); // R5

endmodule

// File: rtl/blk_tdm_rx_lane.sv
module blk_tdm_rx_lane #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] word_nxt
);

    logic [W-1:0] shreg;

    // Word as it stands once the bit on din has been taken in
    assign word_nxt = {shreg[W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (en) begin
            shreg <= word_nxt;
        end
    end

    AST_LANE_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
        en |=> (shreg[0] == $past(din))); // R3

endmodule

// File: rtl/blk_tdm_rx.sv
module blk_tdm_rx
    import blk_tdm_rx_pkg::*;
#(
    parameter int SLOTS     = DEF_SLOTS,
    parameter int SLOT_BITS = DEF_SLOT_BITS,
    parameter int LANES     = DEF_LANES,
    localparam int SW       = idx_bits(SLOTS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       fsync,
    input  logic [LANES-1:0]           sdata,
    output logic                       word_valid,
    output logic [SW-1:0]              slot_idx,
    output logic [LANES*SLOT_BITS-1:0] word_data,
    output logic                       last_slot,
    output logic                       sync_err
);

    localparam int BW = idx_bits(SLOT_BITS);

    rx_state_e           t_state;
    logic [BW-1:0]       t_bit;
    logic [SW-1:0]       t_slot;
    rx_evt_t             t_evt;
    logic [LANES*SLOT_BITS-1:0] lane_nxt;

    blk_tdm_rx_timing #(
        .SLOTS     (SLOTS),
        .SLOT_BITS (SLOT_BITS),
        .SW        (SW),
        .BW        (BW)
    ) u_timing (
        .clk      (clk),
        .rst      (rst),
        .fsync    (fsync),
        .state    (t_state),
        .bit_idx  (t_bit),
        .slot_idx (t_slot),
        .evt      (t_evt),
        .sync_err (sync_err)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        blk_tdm_rx_lane #(
            .W (SLOT_BITS)
        ) u_lane (
            .clk      (clk),
            .rst      (rst),
            .en       (t_state == ST_LOCK),
            .din      (sdata[g]),
            .word_nxt (lane_nxt[g*SLOT_BITS +: SLOT_BITS])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_valid <= 1'b0;
            last_slot  <= 1'b0;
            slot_idx   <= '0;
            word_data  <= '0;
        end else begin
            word_valid <= t_evt.word_done;
            last_slot  <= t_evt.block_end;
            if (t_evt.word_done) begin
                slot_idx  <= t_slot;
                word_data <= lane_nxt;
            end
        end
    end

    AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid); // R4

    AST_LAST_WITH_WORD: assert property (@(posedge clk) disable iff (rst)
        last_slot |-> (word_valid && (slot_idx == SW'(SLOTS - 1)))); // R6

    AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (t_state == ST_HUNT) |=> !word_valid); // R1

endmodule

// File: tb/blk_tdm_rx_tb.sv
module blk_tdm_rx_tb;

    localparam int SLOTS = 384;
    localparam int SB    = 32;
    localparam int NP    = 2;

    // {mode[1:0], seed[31:0]}: 0 hashed, 1 all ones, 2 all zeros, 3 alternating
    localparam logic [33:0] TBL [4] = '{
        {2'd0, 32'h1234_5678},
        {2'd1, 32'h0000_0000},
        {2'd3, 32'h0000_0000},
        {2'd0, 32'hDEAD_BEEF}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fsync = 1'b0;
    logic [NP-1:0] sdata = '0;
    logic wv, ls, se;
    logic [8:0] sidx;
    logic [NP*SB-1:0] wd;

    always #10 clk = ~clk;

    blk_tdm_rx u_dut (
        .clk        (clk),
        .rst        (rst),
        .fsync      (fsync),
        .sdata      (sdata),
        .word_valid (wv),
        .slot_idx   (sidx),
        .word_data  (wd),
        .last_slot  (ls),
        .sync_err   (se)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done = 1'b0;

    logic [8:0]  q_slot [1024];
    logic [31:0] q_w0   [1024];
    logic [31:0] q_w1   [1024];
    int wr = 0;
    int rd = 0;

    function automatic logic [31:0] pat(input int mode, input logic [31:0] seed,
                                        input int slot, input int pin);
        case (mode)
            0:       return (seed + 32'(slot) * 32'h9E37_79B1) ^ (32'(pin) * 32'h85EB_CA6B);
            1:       return 32'hFFFF_FFFF;
            2:       return 32'h0000_0000;
            default: return ((pin != 0) ? 32'h5555_5555 : 32'hAAAA_AAAA) ^ 32'(slot);
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h exp %h", req, what, act, exp);
        end
    endtask

    // Drive one slot MSB first; optionally raise the block start on its last bit
    task automatic drive_slot(input int mode, input logic [31:0] seed,
                              input int slot, input bit fs_last);
        logic [31:0] w0, w1;
        w0 = pat(mode, seed, slot, 0);
        w1 = pat(mode, seed, slot, 1);
        for (int b = 0; b < SB; b++) begin
            @(negedge clk);
            sdata[0] = w0[31-b];
            sdata[1] = w1[31-b];
            fsync    = fs_last && (b == SB - 1);
            if (b == SB - 1) begin
                q_slot[wr % 1024] = 9'(slot % SLOTS);
                q_w0[wr % 1024]   = w0;
                q_w1[wr % 1024]   = w1;
                wr++;
            end
        end
    endtask

    task automatic idle_rand(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fsync = 1'b0;
            sdata = NP'($urandom);
        end
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            fsync = 1'b0;
        end
        check(rd == wr, req, "words missing", 64'(wr - rd), 64'd0);
    endtask

    // Monitor: every strobe must match the next expected slot
    always @(negedge clk) begin
        if (!rst) begin
            if (wv) begin
                if (rd == wr) begin
                    check(1'b0, "R1", "unexpected word, slot", 64'(sidx), 64'd0);
                end else begin
                    check(sidx == q_slot[rd % 1024], "R5", "slot index",
                          64'(sidx), 64'(q_slot[rd % 1024]));
                    check(wd[31:0] == q_w0[rd % 1024], "R3", "pin0 word",
                          64'(wd[31:0]), 64'(q_w0[rd % 1024]));
                    check(wd[63:32] == q_w1[rd % 1024], "R9", "pin1 word",
                          64'(wd[63:32]), 64'(q_w1[rd % 1024]));
                    check(ls == (q_slot[rd % 1024] == 9'd383), "R6", "last flag",
                          64'(ls), 64'(q_slot[rd % 1024] == 9'd383));
                    rd++;
                end
            end else if (ls) begin
                check(1'b0, "R6", "last flag without word", 64'd1, 64'd0);
            end
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!wv && !ls && !se && wd == '0 && sidx == '0, "R1", "reset outputs",
              {wv, ls, se, sidx}, 64'd0);
        rst = 1'b0;

        // R1: noise while hunting yields no words
        idle_rand(70);
        drain("R1");

        // R2: first block start; data on the pulse cycle must not reach slot 0
        @(negedge clk);
        fsync = 1'b1;
        sdata = '1;

        // Table walk: full aligned blocks, each ending with an aligned pulse (R2, R4, R5, R6)
        for (int i = 0; i < 4; i++) begin
            for (int s = 0; s < SLOTS; s++) begin
                drive_slot(int'(TBL[i][33:32]), TBL[i][31:0], s, s == SLOTS - 1);
            end
        end

        // R8: aligned pulses and the hunting pulse left the flag low
        drive_slot(0, 32'hA5A5_0F0F, 0, 1'b0);
        check(se == 1'b0, "R8", "error after aligned pulses", 64'(se), 64'd0);

        // R8: early pulse in the middle of slot 10
        for (int s = 1; s < 10; s++) begin
            drive_slot(0, 32'hA5A5_0F0F, s, 1'b0);
        end
        for (int b = 0; b < 5; b++) begin
            @(negedge clk);
            sdata = NP'($urandom);
        end
        @(negedge clk);
        fsync = 1'b1;
        sdata = '1;
        for (int s = 0; s < 3; s++) begin
            drive_slot(0, 32'h0BAD_CAFE, s, 1'b0);
        end
        check(se == 1'b1, "R8", "error after early pulse", 64'(se), 64'd1);

        // R7: no pulse, the count runs through 383 and wraps to 0, 1
        for (int s = 3; s < SLOTS + 2; s++) begin
            drive_slot(2 * (s % 2), 32'h7777_1111, s, 1'b0);
        end
        drain("R7");
        check(se == 1'b1, "R8", "error flag sticky", 64'(se), 64'd1);

        // R1: reset clears the flag and returns to hunting
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(se == 1'b0 && wv == 1'b0, "R1", "flag after reset", {se, wv}, 64'd0);
        rst = 1'b0;
        idle_rand(40);
        drain("R1");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule